// File: doc/BRIEF.md
# Atomic Deadline Update Engine

This block sits between the host register bus and a bank of 64-bit deadline comparators. It turns single 32-bit host writes into complete 64-bit deadline updates. An absolute write takes its upper half from a scratch word. A relative write adds an unsigned delay to the live time base. An offset write adds a sign-extended 32-bit value to the current deadline. A chain write shifts values down from each deadline's higher neighbour. Each kind of write can also switch on the interrupt of the deadline it touched.

The write path is combinational. The strobes, the new values and the interrupt-enable requests appear in the same cycle as the bus write, so the compare unit latches them at the next clock edge. A busy flag goes with every update so that the compare unit skips its comparison in that cycle. The read path has a one-cycle latency. A read of a deadline value word returns the low half of the deadline and, in the same cycle, hands the high half to the scratch word.

Top module: `deadline_update_engine`

## Requirements
- R1: Lane k (0-based, k < NUM_DL) has three write words. The absolute word is at 0x80+0x10*k, the relative word at +0x4 and the offset word at +0x8. Writes to the +0xC word, to lanes at k >= NUM_DL, to addresses that are not word aligned or to any other address strobe no lane. A non-chain write strobes at most one lane.
- R2: An absolute write strobes lane k in the same cycle. The new value is {scratch, wr_data}.
- R3: A relative write gives now + zero-extended wr_data. A carry into the upper half is kept.
- R4: An offset write gives the lane's current value plus wr_data sign-extended to 64 bits.
- R5: A write to 0x2C is a chain write. Each set bit k with k < NUM_DL-1 loads lane k with the value that lane k+1 held before the write. All lanes read their sources before the write. The top lane and bits k >= NUM_DL-1 are never affected.
- R6: auto_ie bit 0 enables interrupts on absolute writes, bit 1 on relative writes, bit 2 on offset writes and bit 3 on chain writes (control bits 1..4). ie_set is raised only on lanes strobed by an operation whose bit is set.
- R7: busy is high in exactly the cycles in which some lane is strobed. Nothing is strobed without wr_en.
- R8: A read of an absolute word of lane k gives, one cycle later, rd_valid=1, rd_data = low half, scr_we=1 and scr_data = high half. Reads of any other address raise neither rd_valid nor scr_we.
- R9: During and right after reset, rd_valid, scr_we, rd_data and scr_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the read path |
| wr_en | input | 1 | Host write this cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Host read this cycle |
| rd_addr | input | ADDR_W | Read byte address |
| now | input | 64 | Current time base |
| scratch | input | 32 | Scratch word, upper half for absolute writes |
| auto_ie | input | 4 | Interrupt auto-enable per operation (abs, rel, offset, chain) |
| dl_cur | input | NUM_DL*64 | Current deadlines, lane k at bits [64k+63:64k] |
| dl_we | output | NUM_DL | Per-lane deadline write strobe |
| dl_nxt | output | NUM_DL*64 | New deadline values, same packing as dl_cur |
| ie_set | output | NUM_DL | Per-lane interrupt-enable set request |
| busy | output | 1 | Update in progress, compare is suppressed |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Low half of the read deadline |
| scr_we | output | 1 | Scratch load strobe |
| scr_data | output | 32 | High half for the scratch word |

## Verification
The bench targets carries that cross the 32-bit boundary in relative writes. An engine that drops the carry would leave the upper half unchanged. Offset writes with negative data check the sign extension: zero-extending instead would push the deadline about 2^32 ticks late rather than moving it earlier. A full-chain write with every bit set catches an engine that reads already-shifted values, because each lane would then receive the same value. The bench also sends writes to the period word, to the missing eighth lane and to unaligned addresses, where a loose decoder would corrupt a deadline. Random traffic covers each auto-enable bit against each operation type.

// File: rtl/dlu_pkg.sv
package dlu_pkg;
  localparam int TW = 64;
  localparam int BW = 32;

  typedef enum logic [2:0] {OP_NONE, OP_ABS, OP_REL, OP_OFS, OP_CHAIN} dl_op_e;

  localparam int AIE_ABS   = 0;
  localparam int AIE_REL   = 1;
  localparam int AIE_OFS   = 2;
  localparam int AIE_CHAIN = 3;

  function automatic logic [TW-1:0] join_abs(input logic [BW-1:0] hi, input logic [BW-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [TW-1:0] rel_to_now(input logic [TW-1:0] t, input logic [BW-1:0] d);
    return t + {{(TW-BW){1'b0}}, d};
  endfunction

  function automatic logic [TW-1:0] add_signed(input logic [TW-1:0] v, input logic [BW-1:0] d);
    return v + {{(TW-BW){d[BW-1]}}, d};
  endfunction
endpackage

// File: rtl/dlu_decode.sv
module dlu_decode
  import dlu_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_DL    = 7,
  parameter int DL_BASE   = 128,
  parameter int CHAIN_ADR = 44,
  localparam int LANE_W   = $clog2(NUM_DL)
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output dl_op_e            op,
  output logic [LANE_W-1:0] lane
);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(DL_BASE);
  localparam logic [ADDR_W-1:0] CHAIN_A = ADDR_W'(CHAIN_ADR);
  localparam logic [ADDR_W:0]   SPAN    = (ADDR_W+1)'(16 * NUM_DL);

  logic [ADDR_W-1:0] rel_a;
  logic              in_bank;

  assign rel_a   = addr - BASE_A;
  assign in_bank = (addr >= BASE_A) && ({1'b0, rel_a} < SPAN);

  always_comb begin
    op   = OP_NONE;
    lane = rel_a[LANE_W+3:4];
    if (en && addr[1:0] == 2'b00) begin
      if (addr == CHAIN_A) begin
        op = OP_CHAIN;
      end else if (in_bank) begin
        unique case (rel_a[3:2])
          2'd0:    op = OP_ABS;
          2'd1:    op = OP_REL;
          2'd2:    op = OP_OFS;
          default: op = OP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dlu_lane.sv
module dlu_lane
  import dlu_pkg::*;
(
  input  dl_op_e        op,
  input  logic          sel,
  input  logic          chain_bit,
  input  logic [BW-1:0] data,
  input  logic [TW-1:0] now,
  input  logic [BW-1:0] scratch,
  input  logic [TW-1:0] cur,
  input  logic [TW-1:0] src,
  input  logic [3:0]    auto_ie,
  output logic          we,
  output logic [TW-1:0] nxt,
  output logic          ie_req
);
  always_comb begin
    we     = 1'b0;
    nxt    = cur;
    ie_req = 1'b0;
    unique case (op)
      OP_ABS: if (sel) begin
        we = 1'b1; nxt = join_abs(scratch, data); ie_req = auto_ie[AIE_ABS];
      end
      OP_REL: if (sel) begin
        we = 1'b1; nxt = rel_to_now(now, data); ie_req = auto_ie[AIE_REL];
      end
      OP_OFS: if (sel) begin
        we = 1'b1; nxt = add_signed(cur, data); ie_req = auto_ie[AIE_OFS];
      end
      OP_CHAIN: if (chain_bit) begin
        we = 1'b1; nxt = src; ie_req = auto_ie[AIE_CHAIN];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dlu_readback.sv
module dlu_readback
  import dlu_pkg::*;
#(
  parameter int NUM_DL  = 7,
  localparam int LANE_W = $clog2(NUM_DL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit,
  input  logic [LANE_W-1:0]    lane,
  input  logic [NUM_DL*TW-1:0] dl_cur,
  output logic                 rd_valid,
  output logic [BW-1:0]        rd_data,
  output logic                 scr_we,
  output logic [BW-1:0]        scr_data
);
  logic [TW-1:0] word;
  assign word = dl_cur[int'(lane)*TW +: TW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      scr_we   <= 1'b0;
      rd_data  <= '0;
      scr_data <= '0;
    end else begin
      rd_valid <= hit;
      scr_we   <= hit;
      if (hit) begin
        rd_data  <= word[BW-1:0];
        scr_data <= word[TW-1:BW];
      end
    end
  end
endmodule

// File: rtl/deadline_update_engine.sv
module deadline_update_engine
  import dlu_pkg::*;
#(
  parameter int NUM_DL    = 7,
  parameter int ADDR_W    = 8,
  parameter int DL_BASE   = 128,
  parameter int CHAIN_ADR = 44,
  localparam int LANE_W   = $clog2(NUM_DL)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BW-1:0]        wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [TW-1:0]        now,
  input  logic [BW-1:0]        scratch,
  input  logic [3:0]           auto_ie,
  input  logic [NUM_DL*TW-1:0] dl_cur,
  output logic [NUM_DL-1:0]    dl_we,
  output logic [NUM_DL*TW-1:0] dl_nxt,
  output logic [NUM_DL-1:0]    ie_set,
  output logic                 busy,
  output logic                 rd_valid,
  output logic [BW-1:0]        rd_data,
  output logic                 scr_we,
  output logic [BW-1:0]        scr_data
);
  dl_op_e            wr_op, rd_op;
  logic [LANE_W-1:0] wr_lane, rd_lane;
  logic              wr_is_chain;
  logic              rd_hit;

  dlu_decode #(.ADDR_W(ADDR_W), .NUM_DL(NUM_DL), .DL_BASE(DL_BASE), .CHAIN_ADR(CHAIN_ADR)) u_wdec (
    .en(wr_en), .addr(wr_addr), .op(wr_op), .lane(wr_lane));

  dlu_decode #(.ADDR_W(ADDR_W), .NUM_DL(NUM_DL), .DL_BASE(DL_BASE), .CHAIN_ADR(CHAIN_ADR)) u_rdec (
    .en(rd_en), .addr(rd_addr), .op(rd_op), .lane(rd_lane));

  assign wr_is_chain = (wr_op == OP_CHAIN);
  assign rd_hit      = (rd_op == OP_ABS);

  for (genvar k = 0; k < NUM_DL; k++) begin : g_lane
    logic [TW-1:0] src_v;
    logic          chain_v;
    if (k < NUM_DL - 1) begin : g_src
      assign src_v   = dl_cur[(k+1)*TW +: TW];
      assign chain_v = wr_data[k];
    end else begin : g_top
      assign src_v   = '0;
      assign chain_v = 1'b0;
    end
    dlu_lane u_lane (
      .op(wr_op), .sel(wr_lane == LANE_W'(k)), .chain_bit(chain_v),
      .data(wr_data), .now(now), .scratch(scratch),
      .cur(dl_cur[k*TW +: TW]), .src(src_v), .auto_ie(auto_ie),
      .we(dl_we[k]), .nxt(dl_nxt[k*TW +: TW]), .ie_req(ie_set[k]));
  end

  assign busy = |dl_we;

  dlu_readback #(.NUM_DL(NUM_DL)) u_rb (
    .clk(clk), .rst_n(rst_n), .hit(rd_hit), .lane(rd_lane), .dl_cur(dl_cur),
    .rd_valid(rd_valid), .rd_data(rd_data), .scr_we(scr_we), .scr_data(scr_data));
endmodule

// File: rtl/dlu_checker.sv
module dlu_checker #(
  parameter int NUM_DL = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_is_chain,
  input logic              rd_hit,
  input logic [NUM_DL-1:0] dl_we,
  input logic [NUM_DL-1:0] ie_set,
  input logic              busy,
  input logic              rd_valid,
  input logic              scr_we
);
  a_r7_no_write_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (dl_we == '0 && !busy));

  a_r1_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_is_chain) |-> $onehot0(dl_we));

  a_r5_top_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_is_chain |-> !dl_we[NUM_DL-1]);

  a_r6_ie_on_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_set & ~dl_we) == '0);

  a_r8_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (rd_valid && scr_we));

  a_r8_no_stray_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> (!rd_valid && !scr_we));
endmodule

bind deadline_update_engine dlu_checker #(.NUM_DL(NUM_DL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_chain(wr_is_chain),
  .rd_hit(rd_hit), .dl_we(dl_we), .ie_set(ie_set), .busy(busy),
  .rd_valid(rd_valid), .scr_we(scr_we));

// File: tb/deadline_update_engine_test.sv
module deadline_update_engine_test;
  localparam int N = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, scratch = '0;
  logic [63:0] now = '0;
  logic [3:0] auto_ie = '0;
  logic [N*64-1:0] dl_cur;
  logic [N-1:0] dl_we, ie_set;
  logic [N*64-1:0] dl_nxt;
  logic busy, rd_valid, scr_we;
  logic [31:0] rd_data, scr_data;

  logic [63:0] mdl [N];
  logic [N-1:0] e_we, e_ie;
  logic [63:0] e_nx [N];
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  always_comb for (int k = 0; k < N; k++) dl_cur[k*64 +: 64] = mdl[k];

  deadline_update_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .now(now), .scratch(scratch), .auto_ie(auto_ie),
    .dl_cur(dl_cur), .dl_we(dl_we), .dl_nxt(dl_nxt), .ie_set(ie_set), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .scr_we(scr_we), .scr_data(scr_data));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected update, restated from R1..R6 by address arithmetic.
  function automatic void predict(input logic [7:0] a, input logic [31:0] d);
    int ai, kind, k;
    e_we = '0; e_ie = '0;
    for (int j = 0; j < N; j++) e_nx[j] = mdl[j];
    ai = int'(a);
    if (ai % 4 != 0) return;
    if (ai == 44) begin
      for (int j = 0; j < N - 1; j++)
        if (d[j]) begin e_we[j] = 1'b1; e_nx[j] = mdl[j+1]; e_ie[j] = auto_ie[3]; end
      return;
    end
    if (ai < 128 || ai >= 128 + 16 * N) return;
    k = (ai - 128) / 16;
    kind = ((ai - 128) % 16) / 4;
    if (kind == 3) return;
    e_we[k] = 1'b1;
    e_ie[k] = auto_ie[kind];
    case (kind)
      0: e_nx[k] = (64'(scratch) << 32) | 64'(d);
      1: e_nx[k] = now + 64'(d);
      default: e_nx[k] = mdl[k] + 64'(signed'(d));
    endcase
  endfunction

  task automatic do_write(input string req, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    predict(a, d);
    check({req, " strobes"}, 64'(dl_we), 64'(e_we));
    check({req, " ie_set R6"}, 64'(ie_set), 64'(e_ie));
    check({req, " busy R7"}, 64'(busy), 64'(|e_we));
    for (int j = 0; j < N; j++)
      if (e_we[j]) check({req, " value"}, dl_nxt[j*64 +: 64], e_nx[j]);
    @(posedge clk);
    #1;
    for (int j = 0; j < N; j++) if (e_we[j]) mdl[j] = e_nx[j];
  endtask

  task automatic do_read(input string req, input logic [7:0] a, input logic hit, input int k);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    check({req, " rd_valid"}, 64'(rd_valid), 64'(hit));
    check({req, " scr_we"}, 64'(scr_we), 64'(hit));
    if (hit) begin
      check({req, " rd_data"}, 64'(rd_data), 64'(mdl[k][31:0]));
      check({req, " scr_data"}, 64'(scr_data), 64'(mdl[k][63:32]));
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] a;
    for (int j = 0; j < N; j++) mdl[j] = 64'(j) * 64'h1111_0000_0001;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R9 rd_valid in reset", 64'(rd_valid), 0);
    check("R9 scr_we in reset", 64'(scr_we), 0);
    check("R9 rd_data in reset", 64'(rd_data), 0);
    check("R7 busy idle", 64'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R9 rd_valid after reset", 64'(rd_valid), 0);
    check("R9 scr_data after reset", 64'(scr_data), 0);

    auto_ie = 4'b0101;
    scratch = 32'hDEAD_BEEF;
    do_write("R2 absolute lane2", 8'hA0, 32'h1234_5678);
    check("R2 lane2 model", mdl[2], 64'hDEAD_BEEF_1234_5678);
    now = 64'h0000_0001_FFFF_FFF0;
    do_write("R3 relative carry lane0", 8'h84, 32'h0000_0020);
    check("R3 carry result", mdl[0], 64'h0000_0002_0000_0010);
    scratch = 32'h0000_0001;
    do_write("R2 absolute lane5", 8'hD0, 32'h0);
    do_write("R4 negative offset lane5", 8'hD8, 32'hFFFF_FFFF);
    check("R4 borrow result", mdl[5], 64'h0000_0000_FFFF_FFFF);
    do_write("R4 positive offset lane6", 8'hE8, 32'h7FFF_FFFF);
    do_write("R1 period word", 8'h8C, 32'hFFFF_FFFF);
    do_write("R1 missing lane", 8'hF0, 32'h1);
    do_write("R1 unaligned", 8'h81, 32'h1);
    auto_ie = 4'b1000;
    for (int j = 0; j < N; j++) begin
      scratch = 32'(j + 16);
      do_write("R2 preset", 8'(128 + 16 * j), 32'(j * 3 + 1));
    end
    do_write("R5 full chain", 8'h2C, 32'hFFFF_FFFF);
    check("R5 lane0 got lane1", mdl[0], {32'd17, 32'd4});
    check("R5 lane5 got lane6", mdl[5], {32'd22, 32'd19});
    check("R5 top lane kept", mdl[6], {32'd22, 32'd19});
    do_write("R5 only unused bits", 8'h2C, 32'hFFFF_FFC0);
    do_write("R5 sparse chain", 8'h2C, 32'h0000_0015);
    do_read("R8 read lane4", 8'hC0, 1'b1, 4);
    do_read("R8 read lane6", 8'hE0, 1'b1, 6);
    do_read("R8 read relative word", 8'h84, 1'b0, 0);
    do_read("R8 read copy word", 8'h2C, 1'b0, 0);

    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0) a = 8'h2C;
      else if (r == 1) a = 8'($urandom);
      else a = 8'(128 + 16 * int'($urandom % 8) + 4 * int'($urandom % 4));
      auto_ie = 4'($urandom);
      scratch = $urandom;
      now = {$urandom, $urandom};
      do_write("R1 R2 R3 R4 R5 random", a, $urandom);
      if (it % 50 == 0) do_read("R8 random read", 8'(128 + 16 * (it % N)), 1'b1, it % N);
    end

    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("R7 no strobe when idle", 64'(dl_we), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule